// File: doc/BRIEF.md
# Critical-Word-First Line Fill Controller

This block handles a read miss of a direct cache whose lines hold four 32-bit words. The block sits between the CPU request path and a four-way word-interleaved memory. When the tag logic outside the block reports a miss, the controller sends one address to memory. That address names the missed word. Memory returns the whole line starting at that word and wrapping around the line. The missed word goes to the CPU in the same cycle it arrives, so the processor restarts before the line is complete. Every returned word is also written into the cache data array through a dedicated fill port.

While the refill is in progress, the controller keeps a private copy of the words received so far, together with a mask of which words have arrived. A further CPU read to the line being filled is answered at once if its word is already present. Otherwise it waits until that word's beat arrives. A new miss to a different line is held off until the current refill has finished, and then starts its own refill. When the last word lands, the mask is cleared. From then on, the cache array answers reads to that line and the controller stays silent.

The memory timing is one address cycle, then six access cycles, then one cycle per word. A line therefore costs 1+6+4 = 11 cycles, and the critical word is available after the first 8 of them.

Top module: `cwf_fill_ctrl`

## Requirements
- R1: After reset, `cpu_ack`, `mem_req`, `fill_we` and `fill_busy` are all low.
- R2: A request with `cpu_miss` high, seen while the block is idle, is accepted at the next clock edge. In the cycle after acceptance, `mem_req` is high for exactly one cycle, and `mem_addr` then equals the missed word address.
- R3: Each word returned by memory is written through the fill port in the cycle it arrives. The word offsets follow the order w, w+1, w+2, w+3 modulo 4, where w is the low 2 bits of the missed address. `fill_line` carries the upper address bits and `fill_data` carries the returned word.
- R4: The missed word is acknowledged to the CPU (`cpu_ack` high, `cpu_rdata` equal to that word) in the same cycle its beat arrives. With the fixed memory timing, this is 8 cycles after the request is first presented.
- R5: `fill_busy` is high from the cycle after acceptance until the edge that takes the fourth word. It stays high while the CPU has already been restarted.
- R6: During a refill, a request for a word of the same line that has already arrived is acknowledged in the same cycle with that word's data.
- R7: During a refill, a request for a word of the same line that has not yet arrived gets no acknowledge until that word's beat arrives. It is acknowledged in that cycle.
- R8: During a refill, a miss to a different line is not acknowledged and issues no memory request. The block accepts it one cycle after the refill ends, so with the fixed timing it is acknowledged 11 cycles after it is first presented, when it is presented right after the earlier critical word.
- R9: The arrived-word mask is cleared when the refill ends. A later request to that line with `cpu_miss` low is not acknowledged by the block.
- R10: While idle, requests with `cpu_miss` low are ignored: no acknowledge, no memory request, and `fill_busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | CPU read request, held until acknowledged |
| cpu_miss | input | 1 | Tag logic reports that the requested line is absent |
| cpu_addr | input | 16 | Word address of the request |
| cpu_ack | output | 1 | Request served by this block this cycle |
| cpu_rdata | output | 32 | Data returned with `cpu_ack` |
| mem_req | output | 1 | Address cycle to memory |
| mem_addr | output | 16 | Word address of the missed (first) word |
| mem_rvalid | input | 1 | Memory returns one word this cycle |
| mem_rdata | input | 32 | Returned word |
| fill_we | output | 1 | Write strobe into the cache data array |
| fill_line | output | 14 | Line index/tag bits of the line being written |
| fill_word | output | 2 | Word offset within the line |
| fill_data | output | 32 | Word written into the array |
| fill_busy | output | 1 | A refill is in progress |

## Verification
If the beat counter or the saved start offset is corrupted, the fill port writes words to the wrong offsets. The error shows at the first wrong beat, which is within four cycles of the first returned word. If the arrived-word mask is stale, a same-line request is answered too early with old buffer data, or too late after its beat has passed. Either fault changes the acknowledge cycle at once. A mask that is not cleared shows up as a spurious acknowledge on the first request to the old line after the refill. A broken hold-off shows as a second memory address cycle during a running refill, or as an acknowledge latency other than eleven cycles.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_ADDR = 2'd1,
    FS_FILL = 2'd2
  } fill_state_e;

  // offset of the beat taken after 'step' earlier beats, starting at 'start'
  function automatic int unsigned wrap_idx(input int unsigned start,
                                           input int unsigned step,
                                           input int unsigned words);
    return (start + step) % words;
  endfunction

endpackage

// File: rtl/cwf_seq.sv
module cwf_seq
  import cwf_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_WORDS = 4,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int LINE_W    = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              mem_rvalid,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              beat_take,
  output logic [OFF_W-1:0]  beat_word,
  output logic              beat_last,
  output logic [LINE_W-1:0] line_addr
);

  fill_state_e       state_q;
  logic [OFF_W-1:0]  crit_q;
  logic [OFF_W-1:0]  cnt_q;
  logic [LINE_W-1:0] line_q;

  assign busy      = (state_q != FS_IDLE);
  assign mem_req   = (state_q == FS_ADDR);
  assign mem_addr  = {line_q, crit_q};
  assign line_addr = line_q;
  assign beat_take = (state_q == FS_FILL) && mem_rvalid;
  assign beat_last = (cnt_q == OFF_W'(LINE_WORDS - 1));
  assign beat_word = OFF_W'(wrap_idx(int'(crit_q), int'(cnt_q), LINE_WORDS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      crit_q  <= '0;
      cnt_q   <= '0;
      line_q  <= '0;
    end else begin
      case (state_q)
        FS_IDLE: if (start) begin
          state_q <= FS_ADDR;
          line_q  <= start_addr[ADDR_W-1:OFF_W];
          crit_q  <= start_addr[OFF_W-1:0];
          cnt_q   <= '0;
        end
        FS_ADDR: state_q <= FS_FILL;
        FS_FILL: if (beat_take) begin
          if (beat_last) begin
            state_q <= FS_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  a_r5_busy_until_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(beat_take && beat_last)) |=> busy);

endmodule

// File: rtl/cwf_linebuf.sv
module cwf_linebuf #(
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int OFF_W     = $clog2(LINE_WORDS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [OFF_W-1:0]      wr_word,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  clear,
  input  logic [OFF_W-1:0]      rd_word,
  output logic [LINE_WORDS-1:0] mask,
  output logic [DATA_W-1:0]     rd_data
);

  logic [DATA_W-1:0] words_q [LINE_WORDS];

  for (genvar gi = 0; gi < LINE_WORDS; gi++) begin : g_word
    logic hit_w;
    assign hit_w = wr_en && (wr_word == OFF_W'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask[gi]    <= 1'b0;
        words_q[gi] <= '0;
      end else begin
        if (clear)      mask[gi] <= 1'b0;
        else if (hit_w) mask[gi] <= 1'b1;
        if (hit_w) words_q[gi] <= wr_data;
      end
    end
  end

  assign rd_data = words_q[rd_word];

  a_r9_mask_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (mask == '0));

  a_r3_mask_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clear && !mask[wr_word]) |=>
      ($countones(mask) == $past($countones(mask)) + 1));

endmodule

// File: rtl/cwf_serve.sv
module cwf_serve #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int LINE_W    = ADDR_W - OFF_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  busy,
  input  logic                  cpu_req,
  input  logic [ADDR_W-1:0]     cpu_addr,
  input  logic [LINE_W-1:0]     line_addr,
  input  logic [LINE_WORDS-1:0] mask,
  input  logic [DATA_W-1:0]     buf_data,
  input  logic                  beat_take,
  input  logic [OFF_W-1:0]      beat_word,
  input  logic [DATA_W-1:0]     beat_data,
  output logic                  hit_buf,
  output logic                  hit_beat,
  output logic                  cpu_ack,
  output logic [DATA_W-1:0]     cpu_rdata
);

  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  logic             same_line;
  logic [OFF_W-1:0] want;

  assign want      = word_of(cpu_addr);
  assign same_line = busy && cpu_req && (line_of(cpu_addr) == line_addr);
  assign hit_buf   = same_line && mask[want];
  assign hit_beat  = same_line && !mask[want] && beat_take && (beat_word == want);
  assign cpu_ack   = hit_buf || hit_beat;

  always_comb begin
    cpu_rdata = '0;
    if (hit_buf)       cpu_rdata = buf_data;
    else if (hit_beat) cpu_rdata = beat_data;
  end

  a_r4_ack_needs_fill: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> (busy && cpu_req));

endmodule

// File: rtl/cwf_fill_ctrl.sv
module cwf_fill_ctrl
  import cwf_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int OFF_W     = $clog2(LINE_WORDS),
  localparam int LINE_W    = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_miss,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              fill_we,
  output logic [LINE_W-1:0] fill_line,
  output logic [OFF_W-1:0]  fill_word,
  output logic [DATA_W-1:0] fill_data,
  output logic              fill_busy
);

  logic                  busy;
  logic                  start_fill;
  logic                  beat_take;
  logic                  beat_last;
  logic                  fill_done;
  logic [OFF_W-1:0]      beat_word;
  logic [LINE_W-1:0]     line_addr;
  logic [LINE_WORDS-1:0] mask;
  logic [DATA_W-1:0]     buf_data;
  logic                  hit_buf;
  logic                  hit_beat;

  assign start_fill = !busy && cpu_req && cpu_miss;
  assign fill_done  = beat_take && beat_last;

  cwf_seq #(.ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_fill),
    .start_addr (cpu_addr),
    .mem_rvalid (mem_rvalid),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .beat_take  (beat_take),
    .beat_word  (beat_word),
    .beat_last  (beat_last),
    .line_addr  (line_addr)
  );

  cwf_linebuf #(.DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (beat_take),
    .wr_word (beat_word),
    .wr_data (mem_rdata),
    .clear   (fill_done),
    .rd_word (cpu_addr[OFF_W-1:0]),
    .mask    (mask),
    .rd_data (buf_data)
  );

  cwf_serve #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)) u_serve (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .cpu_req   (cpu_req),
    .cpu_addr  (cpu_addr),
    .line_addr (line_addr),
    .mask      (mask),
    .buf_data  (buf_data),
    .beat_take (beat_take),
    .beat_word (beat_word),
    .beat_data (mem_rdata),
    .hit_buf   (hit_buf),
    .hit_beat  (hit_beat),
    .cpu_ack   (cpu_ack),
    .cpu_rdata (cpu_rdata)
  );

  assign fill_we   = beat_take;
  assign fill_line = line_addr;
  assign fill_word = beat_word;
  assign fill_data = mem_rdata;
  assign fill_busy = busy;

  a_r8_req_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mask == '0));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_busy |-> (!cpu_ack && !fill_we));

  a_r6_single_source: assert property (@(posedge clk) disable iff (!rst_n)
    hit_buf |-> !fill_we || (fill_word != cpu_addr[OFF_W-1:0]));

endmodule

// File: tb/tb_cwf_fill_ctrl.sv
`timescale 1ns/1ps
module tb_cwf_fill_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic        cpu_miss = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_ack;
  logic [31:0] cpu_rdata;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        fill_we;
  logic [13:0] fill_line;
  logic [1:0]  fill_word;
  logic [31:0] fill_data;
  logic        fill_busy;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  cwf_fill_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_miss(cpu_miss), .cpu_addr(cpu_addr),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .fill_we(fill_we), .fill_line(fill_line), .fill_word(fill_word),
    .fill_data(fill_data), .fill_busy(fill_busy)
  );

  function automatic logic [31:0] memf(input logic [15:0] a);
    return {a ^ 16'hB3E5, a};
  endfunction

  // memory model: address cycle, 6 access cycles, one word per cycle wrapped
  logic [15:0] m_base;
  int          mcnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      mcnt       <= 0;
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else if (mem_req) begin
      mcnt       <= 1;
      m_base     <= mem_addr;
      mem_rvalid <= 1'b0;
    end else if (mcnt != 0) begin
      if (mcnt >= 6 && mcnt <= 9) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= memf({m_base[15:2], m_base[1:0] + 2'(mcnt - 6)});
      end else begin
        mem_rvalid <= 1'b0;
      end
      mcnt <= (mcnt == 9) ? 0 : mcnt + 1;
    end else begin
      mem_rvalid <= 1'b0;
    end
  end

  // port monitors
  int          fcount;
  logic [1:0]  flog_word [16];
  logic [13:0] flog_line [16];
  logic [31:0] flog_data [16];
  int          mreq_cnt;
  logic [15:0] mreq_addr;
  always @(posedge clk) begin
    if (rst_n && fill_we && fcount < 16) begin
      flog_word[fcount] = fill_word;
      flog_line[fcount] = fill_line;
      flog_data[fcount] = fill_data;
      fcount = fcount + 1;
    end
    if (rst_n && mem_req) begin
      mreq_cnt  = mreq_cnt + 1;
      mreq_addr = mem_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic miss, input int maxw,
                        output logic got, output logic [31:0] d, output int waits);
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = a; cpu_miss = miss;
    got = 1'b0; d = '0; waits = 0;
    while (!got && waits < maxw) begin
      #1;
      if (cpu_ack) begin
        got = 1'b1;
        d = cpu_rdata;
      end else begin
        @(negedge clk);
        waits++;
      end
    end
    if (got) begin
      @(posedge clk);
      #1;
    end
    cpu_req = 1'b0; cpu_miss = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (fill_busy && n < 40) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  task automatic check_order(input int base, input logic [15:0] a, input string req);
    for (int i = 0; i < 4; i++) begin
      logic [1:0] ew;
      ew = a[1:0] + 2'(i);
      chk(flog_word[base+i] == ew, req, 64'(flog_word[base+i]), 64'(ew));
      chk(flog_line[base+i] == a[15:2], req, 64'(flog_line[base+i]), 64'(a[15:2]));
      chk(flog_data[base+i] == memf({a[15:2], ew}), req,
          64'(flog_data[base+i]), 64'(memf({a[15:2], ew})));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!cpu_ack,   "R1 ack",  64'(cpu_ack), 0);
    chk(!mem_req,   "R1 req",  64'(mem_req), 0);
    chk(!fill_we,   "R1 we",   64'(fill_we), 0);
    chk(!fill_busy, "R1 busy", 64'(fill_busy), 0);
  endtask

  task automatic t_basic();
    logic got; logic [31:0] d; int w;
    logic [15:0] a = {14'h0012, 2'd2};
    fcount = 0; mreq_cnt = 0;
    access(a, 1'b1, 30, got, d, w);
    chk(got && w == 8, "R4 latency", 64'(w), 8);
    chk(d == memf(a), "R4 data", 64'(d), 64'(memf(a)));
    chk(mreq_cnt == 1, "R2 pulses", 64'(mreq_cnt), 1);
    chk(mreq_addr == a, "R2 addr", 64'(mreq_addr), 64'(a));
    chk(fill_busy, "R5 busy after restart", 64'(fill_busy), 1);
    access(a, 1'b1, 5, got, d, w);
    chk(got && w == 0, "R6 buffered wait", 64'(w), 0);
    chk(d == memf(a), "R6 buffered data", 64'(d), 64'(memf(a)));
    access({14'h0012, 2'd1}, 1'b0, 10, got, d, w);
    chk(got && w == 1, "R7 stall wait", 64'(w), 1);
    chk(d == memf({14'h0012, 2'd1}), "R7 data", 64'(d), 64'(memf({14'h0012, 2'd1})));
    chk(!fill_busy, "R5 busy low after last", 64'(fill_busy), 0);
    chk(fcount == 4, "R3 count", 64'(fcount), 4);
    check_order(0, a, "R3 order");
    access({14'h0012, 2'd3}, 1'b0, 3, got, d, w);
    chk(!got, "R9 no ack after clear", 64'(got), 0);
  endtask

  task automatic t_word0();
    logic got; logic [31:0] d; int w;
    logic [15:0] a = {14'h00A5, 2'd0};
    fcount = 0;
    access(a, 1'b1, 30, got, d, w);
    chk(got && w == 8, "R4 latency w0", 64'(w), 8);
    chk(d == memf(a), "R4 data w0", 64'(d), 64'(memf(a)));
    wait_idle();
    check_order(0, a, "R3 order w0");
  endtask

  task automatic t_holdoff();
    logic got; logic [31:0] d; int w;
    logic [15:0] a = {14'h0031, 2'd3};
    logic [15:0] b = {14'h0077, 2'd1};
    fcount = 0; mreq_cnt = 0;
    access(a, 1'b1, 30, got, d, w);
    chk(got && w == 8, "R4 latency A", 64'(w), 8);
    access(b, 1'b1, 40, got, d, w);
    chk(got && w == 11, "R8 held-off latency", 64'(w), 11);
    chk(d == memf(b), "R8 data", 64'(d), 64'(memf(b)));
    chk(mreq_cnt == 2, "R8 requests", 64'(mreq_cnt), 2);
    chk(mreq_addr == b, "R8 second addr", 64'(mreq_addr), 64'(b));
    wait_idle();
    check_order(0, a, "R3 order A");
    check_order(4, b, "R8 order B");
  endtask

  task automatic t_idle_hit();
    logic got; logic [31:0] d; int w;
    mreq_cnt = 0;
    access({14'h0040, 2'd1}, 1'b0, 4, got, d, w);
    chk(!got, "R10 no ack", 64'(got), 0);
    chk(mreq_cnt == 0, "R10 no mem req", 64'(mreq_cnt), 0);
    chk(!fill_busy, "R10 stays idle", 64'(fill_busy), 0);
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    fcount = 0; mreq_cnt = 0; mreq_addr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_word0();
    t_holdoff();
    t_idle_hit();
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=done");
    finish_up();
  end

endmodule